// File: doc/BRIEF.md
# Tagged Point-to-Point Stream Channel

This block joins a processor to a hardware accelerator with two one-way FIFO links, one in each direction, and has no arbitration. Every word in a link is 32 data bits plus a tag bit. The tag is 1 for a control word and 0 for a data word. On the processor side, writes and reads come in data and control kinds. Each can be issued in a stalling (blocking) form or a non-stalling (non-blocking) form. A non-blocking request always completes in the cycle it is issued and reports whether it succeeded. A read also reports whether its kind matched the tag of the word it removed.

The accelerator side has a valid/ready port on each link. The outbound port carries words the processor wrote. The inbound port carries words the processor will read. Each link holds a parameterised number of words, 16 by default. Its full and empty flags are registered. At full, a write and a read in the same cycle are both accepted.

Top module: `tagstream_link`

## Requirements
- R1: A write with `cpu_put_ctrl`=1 stores tag 1 and one with `cpu_put_ctrl`=0 stores tag 0. The stored tag appears on `acc_out_ctrl` when the word reaches the head of the outbound link. `cpu_put_ok` is high in exactly the cycles in which the word is stored.
- R2: The outbound link delivers stored words in write order. `acc_out_valid` is high whenever at least one word is stored. While `acc_out_ready` is low, the head word and its tag hold steady.
- R3: A blocking write (`cpu_put_nb`=0) while the outbound link holds DEPTH words raises `cpu_put_stall` and stores nothing, unless the accelerator takes a word in the same cycle. In that case the write is stored.
- R4: A non-blocking write (`cpu_put_nb`=1) to a full outbound link, with no word taken that cycle, drops the word. It raises `cpu_put_fail` and never raises `cpu_put_stall`.
- R5: A blocking read (`cpu_get_nb`=0) from an empty inbound link raises `cpu_get_stall`, keeps `cpu_get_ok` low and removes nothing.
- R6: A non-blocking read from an empty inbound link raises `cpu_get_fail`, returns `cpu_get_data`=0 and removes nothing.
- R7: A read from a non-empty inbound link removes the head word, returns its data and raises `cpu_get_ok`. It raises `cpu_get_mismatch` when the requested kind (`cpu_get_ctrl`: 1=control, 0=data) differs from the word's tag. The word is removed even when the kinds differ.
- R8: `acc_in_ready` is low only when the inbound link holds DEPTH words and the processor reads nothing in that cycle. Accepted inbound words reach the processor in arrival order with their tags.
- R9: After reset both links are empty: `acc_out_valid`=0 and `acc_in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_put_req | input | 1 | Processor write request |
| cpu_put_ctrl | input | 1 | 1 = control write, 0 = data write |
| cpu_put_nb | input | 1 | 1 = non-blocking write |
| cpu_put_data | input | 32 | Write data |
| cpu_put_ok | output | 1 | Write stored this cycle |
| cpu_put_fail | output | 1 | Non-blocking write dropped |
| cpu_put_stall | output | 1 | Blocking write must wait |
| cpu_get_req | input | 1 | Processor read request |
| cpu_get_ctrl | input | 1 | 1 = control read, 0 = data read |
| cpu_get_nb | input | 1 | 1 = non-blocking read |
| cpu_get_data | output | 32 | Read data, 0 when no word is taken |
| cpu_get_ok | output | 1 | Word taken this cycle |
| cpu_get_fail | output | 1 | Non-blocking read found nothing |
| cpu_get_stall | output | 1 | Blocking read must wait |
| cpu_get_mismatch | output | 1 | Taken word's tag differs from the requested kind |
| acc_out_valid | output | 1 | Outbound word available |
| acc_out_ready | input | 1 | Accelerator takes the outbound word |
| acc_out_data | output | 32 | Outbound word data |
| acc_out_ctrl | output | 1 | Outbound word tag |
| acc_in_valid | input | 1 | Accelerator offers an inbound word |
| acc_in_ready | output | 1 | Inbound word accepted |
| acc_in_data | input | 32 | Inbound word data |
| acc_in_ctrl | input | 1 | Inbound word tag |

## Verification
A wrong occupancy count shows at the ports within one cycle of reaching a boundary:

- At the wrong fill level, a write stalls or fails when it should succeed.
- `acc_in_ready` drops early or late.
- A read returns a stale or zero word where a live one was due.

A corrupted pointer or a corrupted tag surfaces as soon as the affected word reaches the head of its link. It then appears as wrong data on `acc_out_data` or `cpu_get_data`, or as a wrong `cpu_get_mismatch`. A cycle-accurate model is compared on every clock, so the first divergent cycle is reported.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic              tag;
    logic [DATA_W-1:0] data;
  } tsl_word_t;

  function automatic tsl_word_t make_word(input logic is_ctrl, input logic [DATA_W-1:0] d);
    tsl_word_t w;
    w.tag  = is_ctrl;
    w.data = d;
    return w;
  endfunction

  function automatic logic kind_mismatch(input logic want_ctrl, input tsl_word_t w);
    return want_ctrl ^ w.tag;
  endfunction

  function automatic logic can_accept(input logic full, input logic pop_now);
    return !full || pop_now;
  endfunction
endpackage

// File: rtl/tsl_fifo.sv
module tsl_fifo #(
  parameter int WIDTH = 33,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LVL_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    level, level_nxt;
  logic             full_q, empty_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    level_nxt = level;
    if (push && !pop) level_nxt = level + 1'b1;
    else if (pop && !push) level_nxt = level - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      level   <= level_nxt;
      full_q  <= (level_nxt == LVL_MAX);
      empty_q <= (level_nxt == '0);
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = full_q;
  assign empty = empty_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full_q || pop));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty_q);
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q));
  assert_empty_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_q && !push) |=> empty_q);
endmodule

// File: rtl/tsl_put_port.sv
module tsl_put_port
  import tsl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              is_ctrl,
  input  logic              nb,
  input  logic [DATA_W-1:0] data,
  input  logic              link_full,
  input  logic              link_pop,
  output logic              push,
  output tsl_word_t         push_word,
  output logic              ok,
  output logic              fail,
  output logic              stall
);
  logic room;

  assign room      = can_accept(link_full, link_pop);
  assign push      = req && room;
  assign push_word = make_word(is_ctrl, data);
  assign ok        = push;
  assign fail      = req && nb && !room;
  assign stall     = req && !nb && !room;

  assert_stall_no_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!push && link_full));
  assert_fail_only_nb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (nb && !stall && !push));
endmodule

// File: rtl/tsl_get_port.sv
module tsl_get_port
  import tsl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              want_ctrl,
  input  logic              nb,
  input  logic              link_empty,
  input  tsl_word_t         head,
  output logic              pop,
  output logic [DATA_W-1:0] data,
  output logic              ok,
  output logic              fail,
  output logic              stall,
  output logic              mismatch
);
  assign pop      = req && !link_empty;
  assign ok       = pop;
  assign data     = pop ? head.data : '0;
  assign mismatch = pop && kind_mismatch(want_ctrl, head);
  assign fail     = req && nb && link_empty;
  assign stall    = req && !nb && link_empty;

  assert_stall_no_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!ok && !pop));
  assert_fail_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (data == '0 && !pop));
  assert_mismatch_pops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> pop);
endmodule

// File: rtl/tagstream_link.sv
module tagstream_link
  import tsl_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_put_req,
  input  logic              cpu_put_ctrl,
  input  logic              cpu_put_nb,
  input  logic [DATA_W-1:0] cpu_put_data,
  output logic              cpu_put_ok,
  output logic              cpu_put_fail,
  output logic              cpu_put_stall,
  input  logic              cpu_get_req,
  input  logic              cpu_get_ctrl,
  input  logic              cpu_get_nb,
  output logic [DATA_W-1:0] cpu_get_data,
  output logic              cpu_get_ok,
  output logic              cpu_get_fail,
  output logic              cpu_get_stall,
  output logic              cpu_get_mismatch,
  output logic              acc_out_valid,
  input  logic              acc_out_ready,
  output logic [DATA_W-1:0] acc_out_data,
  output logic              acc_out_ctrl,
  input  logic              acc_in_valid,
  output logic              acc_in_ready,
  input  logic [DATA_W-1:0] acc_in_data,
  input  logic              acc_in_ctrl
);
  localparam int WORD_W = $bits(tsl_word_t);

  // outbound link (processor -> accelerator)
  logic      ob_push, ob_pop, ob_full, ob_empty;
  tsl_word_t ob_in_word, ob_head;

  // inbound link (accelerator -> processor)
  logic      ib_push, ib_pop, ib_full, ib_empty;
  tsl_word_t ib_in_word, ib_head;

  tsl_put_port u_put (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (cpu_put_req),
    .is_ctrl   (cpu_put_ctrl),
    .nb        (cpu_put_nb),
    .data      (cpu_put_data),
    .link_full (ob_full),
    .link_pop  (ob_pop),
    .push      (ob_push),
    .push_word (ob_in_word),
    .ok        (cpu_put_ok),
    .fail      (cpu_put_fail),
    .stall     (cpu_put_stall)
  );

  tsl_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_ob_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ob_push),
    .push_data (ob_in_word),
    .pop       (ob_pop),
    .head      (ob_head),
    .full      (ob_full),
    .empty     (ob_empty)
  );

  assign acc_out_valid = !ob_empty;
  assign ob_pop        = acc_out_valid && acc_out_ready;
  assign acc_out_data  = ob_head.data;
  assign acc_out_ctrl  = ob_head.tag;

  assign ib_in_word   = make_word(acc_in_ctrl, acc_in_data);
  assign acc_in_ready = can_accept(ib_full, ib_pop);
  assign ib_push      = acc_in_valid && acc_in_ready;

  tsl_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_ib_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ib_push),
    .push_data (ib_in_word),
    .pop       (ib_pop),
    .head      (ib_head),
    .full      (ib_full),
    .empty     (ib_empty)
  );

  tsl_get_port u_get (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (cpu_get_req),
    .want_ctrl  (cpu_get_ctrl),
    .nb         (cpu_get_nb),
    .link_empty (ib_empty),
    .head       (ib_head),
    .pop        (ib_pop),
    .data       (cpu_get_data),
    .ok         (cpu_get_ok),
    .fail       (cpu_get_fail),
    .stall      (cpu_get_stall),
    .mismatch   (cpu_get_mismatch)
  );

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_out_valid && !acc_out_ready) |=>
      (acc_out_valid && $stable(acc_out_data) && $stable(acc_out_ctrl)));
  assert_put_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_empty && cpu_put_ok) |=> (acc_out_ctrl == $past(cpu_put_ctrl)));
  assert_in_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_in_ready |-> (ib_full && !cpu_get_req));
endmodule

// File: tb/tagstream_link_tb.sv
module tagstream_link_tb;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        pr = 0, pc = 0, pn = 0;
  logic [31:0] pd = 0;
  logic        gr = 0, gc = 0, gn = 0;
  logic        aor = 0, aiv = 0, aic = 0;
  logic [31:0] aid = 0;

  logic        put_ok, put_fail, put_stall;
  logic [31:0] get_data;
  logic        get_ok, get_fail, get_stall, get_mm;
  logic        out_v, out_c, in_rdy;
  logic [31:0] out_d;

  tagstream_link #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_put_req(pr), .cpu_put_ctrl(pc), .cpu_put_nb(pn), .cpu_put_data(pd),
    .cpu_put_ok(put_ok), .cpu_put_fail(put_fail), .cpu_put_stall(put_stall),
    .cpu_get_req(gr), .cpu_get_ctrl(gc), .cpu_get_nb(gn),
    .cpu_get_data(get_data), .cpu_get_ok(get_ok), .cpu_get_fail(get_fail),
    .cpu_get_stall(get_stall), .cpu_get_mismatch(get_mm),
    .acc_out_valid(out_v), .acc_out_ready(aor), .acc_out_data(out_d), .acc_out_ctrl(out_c),
    .acc_in_valid(aiv), .acc_in_ready(in_rdy), .acc_in_data(aid), .acc_in_ctrl(aic)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [32:0] txq[$];
  logic [32:0] rxq[$];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare mid-low-phase, then advance model as the coming edge will
  task automatic tick();
    logic tx_v, tx_pop, room, e_ok, e_fail, e_stall;
    logic g_ok, g_mm, g_stall, g_fail, rdy;
    logic [31:0] g_data;
    #2;
    tx_v   = (txq.size() > 0);
    tx_pop = tx_v && aor;
    chk("R2", "acc_out_valid", out_v, tx_v);
    if (tx_v) begin
      chk("R2", "acc_out_data", out_d, txq[0][31:0]);
      chk("R1", "acc_out_ctrl", out_c, txq[0][32]);
    end
    room    = (txq.size() < DEPTH) || tx_pop;
    e_ok    = pr && room;
    e_fail  = pr && pn && !room;
    e_stall = pr && !pn && !room;
    chk("R1", "cpu_put_ok", put_ok, e_ok);
    chk("R4", "cpu_put_fail", put_fail, e_fail);
    chk("R3", "cpu_put_stall", put_stall, e_stall);
    g_ok    = gr && (rxq.size() > 0);
    g_data  = g_ok ? rxq[0][31:0] : 32'd0;
    g_mm    = g_ok && (rxq[0][32] != gc);
    g_stall = gr && !gn && (rxq.size() == 0);
    g_fail  = gr && gn && (rxq.size() == 0);
    chk("R7", "cpu_get_ok", get_ok, g_ok);
    chk("R6", "cpu_get_data", get_data, g_data);
    chk("R7", "cpu_get_mismatch", get_mm, g_mm);
    chk("R5", "cpu_get_stall", get_stall, g_stall);
    chk("R6", "cpu_get_fail", get_fail, g_fail);
    rdy = (rxq.size() < DEPTH) || g_ok;
    chk("R8", "acc_in_ready", in_rdy, rdy);
    if (tx_pop) void'(txq.pop_front());
    if (e_ok) txq.push_back({pc, pd});
    if (g_ok) void'(rxq.pop_front());
    if (aiv && rdy) rxq.push_back({aic, aid});
    @(negedge clk);
  endtask

  task automatic idle();
    pr = 0; gr = 0; aor = 0; aiv = 0;
  endtask

  task automatic put(input logic c, input logic nb, input logic [31:0] d);
    pr = 1; pc = c; pn = nb; pd = d;
  endtask

  task automatic get(input logic c, input logic nb);
    gr = 1; gc = c; gn = nb;
  endtask

  task automatic acc_push(input logic c, input logic [31:0] d);
    aiv = 1; aic = c; aid = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    #2;
    chk("R9", "acc_out_valid in reset", out_v, 0);
    chk("R9", "acc_in_ready in reset", in_rdy, 1);
    @(negedge clk);
    rst_n = 1;
    idle(); tick();

    // fill outbound with alternating tags (R1, R2)
    for (int i = 0; i < DEPTH; i++) begin
      idle(); put(i[0], 0, 32'hA000 + i); tick();
    end
    idle(); put(0, 0, 32'hDEAD); tick();          // R3 blocking write stalls
    idle(); put(1, 1, 32'hBEEF); tick();          // R4 non-blocking write dropped
    idle(); put(1, 0, 32'hCAFE); aor = 1; tick(); // R3 write and drain at full
    for (int i = 0; i < DEPTH + 2; i++) begin
      idle(); aor = 1; tick();
    end

    // inbound fill and reads (R5..R8)
    idle(); get(0, 0); tick();                    // R5 blocking read from empty
    idle(); get(1, 1); tick();                    // R6 non-blocking read from empty
    for (int i = 0; i < DEPTH + 1; i++) begin
      idle(); acc_push(i[1], 32'hB000 + i); tick(); // last one refused (R8)
    end
    idle(); acc_push(1, 32'h5A5A); get(0, 1); tick(); // R8 read frees room same cycle
    for (int i = 0; i < DEPTH + 2; i++) begin
      idle(); get(i[0], i[2]); tick();            // R7 matched and mismatched reads
    end

    // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      idle();
      if ($urandom_range(0, 3) != 0) put($urandom_range(0, 1), $urandom_range(0, 1), $urandom);
      if ($urandom_range(0, 2) == 0) get($urandom_range(0, 1), $urandom_range(0, 1));
      aor = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 1) == 0) acc_push($urandom_range(0, 1), $urandom);
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule